// File: doc/BRIEF.md
# Logic Analyzer Command Decoder

This block sits behind a UART-style byte receiver and turns the host's command stream into the configuration of a logic analyzer capture engine. Each received byte arrives on an 8-bit data input qualified by a one-cycle valid strobe. The decoder sorts opcodes into two length classes. Single-byte commands carry no argument. Five-byte commands carry an opcode followed by a 32-bit argument sent least significant byte first. Every complete command is announced with a one-cycle strobe that carries its opcode and argument.

Complete commands update a bank of configuration registers. These are a mask, a match value and a config word for each trigger stage, the sample-rate divider, the read and delay counts (minus one), and the capture flag word. Single-byte commands raise reset and arm pulses for the sampling core. Capture size can be loaded in two ways: one packed command holds both counts, or two separate commands hold the full-width values.

Top module: `la_cmd_decoder`

## Requirements
- R1: An opcode with bit 7 set starts a long command. The next four valid bytes form its argument, with the first of them at bits 7:0 and the fourth at bits 31:24. In the cycle after the fourth argument byte is accepted, `cmd_strobe_o` is high for one cycle with that opcode and argument.
- R2: An opcode with bit 7 clear is a short command. In the cycle after it is accepted, `cmd_strobe_o` is high for one cycle with that opcode and a zero argument.
- R3: For stage n (0 to STAGES-1), opcode 0xC0+4n writes the stage mask, 0xC1+4n writes the stage match value and 0xC2+4n writes the stage config word. Each takes the full 32-bit argument and appears on the flattened bus slice [32n+31:32n] one cycle after the strobe.
- R4: `trig_start_o[n]` follows bit 27 of stage n's config word. This bit is the flag that marks the stage whose match begins the capture. Bits 23:16 of the config word hold the stage number and are kept as written.
- R5: Opcode 0x80 loads the sample-rate divider with bits 23:0 of its argument. Bits 31:24 are dropped.
- R6: Opcode 0x81 is the packed capture size. Bits 15:0 of its argument go to the read-count-minus-one register, and bits 31:16 go to the delay-count-minus-one register. The upper halves of both registers become zero.
- R7: Opcode 0x83 loads the full 32-bit read-count-minus-one register, and opcode 0x84 loads the full 32-bit delay-count-minus-one register.
- R8: Opcode 0x82 loads the 32-bit flag word. `group_off_o` shows its bits 5:2, the per-channel-group disable bits, where 1 means the group is off.
- R9: Short opcode 0x00 clears every configuration register to zero and raises `reset_pulse_o` for one cycle, one cycle after the strobe.
- R10: Five consecutive 0x00 bytes leave the decoder idle from any state. The byte that follows them is taken as a new opcode.
- R11: Short opcode 0x01 raises `arm_pulse_o` for one cycle, one cycle after the strobe.
- R12: Any other opcode is consumed according to its length class and changes no configuration register. This includes 0xC3+4n and trigger opcodes for stages at or beyond STAGES. The command that follows it is still framed correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_data_i | input | 8 | Received byte |
| rx_valid_i | input | 1 | Byte qualifier, one cycle per byte |
| cmd_strobe_o | output | 1 | One-cycle complete-command strobe |
| cmd_opcode_o | output | 8 | Opcode of the strobed command |
| cmd_arg_o | output | 32 | Argument of the strobed command |
| trig_mask_o | output | 32*STAGES | Stage masks, stage n at [32n+31:32n] |
| trig_value_o | output | 32*STAGES | Stage match values |
| trig_cfg_o | output | 32*STAGES | Stage config words |
| trig_start_o | output | STAGES | Start flag of each stage |
| divider_o | output | 24 | Sample-rate divider |
| read_m1_o | output | 32 | Read count minus one |
| delay_m1_o | output | 32 | Delay count minus one |
| flags_o | output | 32 | Capture flag word |
| group_off_o | output | 4 | Channel-group disable bits |
| reset_pulse_o | output | 1 | Reset pulse to the capture engine |
| arm_pulse_o | output | 1 | Arm pulse to the capture engine |

## Verification
The properties assume that a valid byte lasts exactly one cycle and that `rx_data_i` carries the byte in the cycle its valid is high. They relate each strobe to the byte seen one cycle earlier. The stimulus drives every byte for one cycle with valid high and then idles one cycle with valid low. Resynchronisation is tested with a long command that is left unfinished before a run of zeros, so the run begins in the middle of a frame.

// File: rtl/la_cmd_pkg.sv
package la_cmd_pkg;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned DIV_W   = 24;
  localparam int unsigned ARG_BYTES = WORD_W / BYTE_W;
  localparam int unsigned CNT_W   = $clog2(ARG_BYTES);
  localparam int unsigned STAGE_W = 2;
  localparam int unsigned START_BIT = 27;
  localparam int unsigned HALF_W  = WORD_W / 2;

  localparam logic [7:0] OP_RESET     = 8'h00;
  localparam logic [7:0] OP_ARM       = 8'h01;
  localparam logic [7:0] OP_DIV       = 8'h80;
  localparam logic [7:0] OP_SIZE_PK   = 8'h81;
  localparam logic [7:0] OP_FLAGS     = 8'h82;
  localparam logic [7:0] OP_READ_CNT  = 8'h83;
  localparam logic [7:0] OP_DELAY_CNT = 8'h84;
  localparam logic [3:0] OP_TRIG_HI   = 4'hC;

  typedef enum logic [1:0] {
    FLD_MASK  = 2'd0,
    FLD_VALUE = 2'd1,
    FLD_CFG   = 2'd2,
    FLD_NONE  = 2'd3
  } trig_fld_e;

  typedef enum logic {
    ASM_IDLE = 1'b0,
    ASM_ARGS = 1'b1
  } asm_state_e;

  typedef struct packed {
    logic [BYTE_W-1:0] op;
    logic [WORD_W-1:0] arg;
  } cmd_t;
endpackage

// File: rtl/la_trig_stage.sv
module la_trig_stage
  import la_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              wr_en_i,
  input  trig_fld_e         fld_i,
  input  logic [WORD_W-1:0] data_i,
  output logic [WORD_W-1:0] mask_o,
  output logic [WORD_W-1:0] value_o,
  output logic [WORD_W-1:0] cfg_o,
  output logic              start_o
);
  logic [WORD_W-1:0] mask_q, mask_d;
  logic [WORD_W-1:0] value_q, value_d;
  logic [WORD_W-1:0] cfg_q, cfg_d;
  logic              en;

  always_comb begin
    mask_d  = mask_q;
    value_d = value_q;
    cfg_d   = cfg_q;
    en      = clear_i | wr_en_i;
    if (clear_i) begin
      mask_d  = '0;
      value_d = '0;
      cfg_d   = '0;
    end else if (wr_en_i) begin
      case (fld_i)
        FLD_MASK:  mask_d  = data_i;
        FLD_VALUE: value_d = data_i;
        FLD_CFG:   cfg_d   = data_i;
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '0;
      value_q <= '0;
      cfg_q   <= '0;
    end else if (en) begin
      mask_q  <= mask_d;
      value_q <= value_d;
      cfg_q   <= cfg_d;
    end
  end

  assign mask_o  = mask_q;
  assign value_o = value_q;
  assign cfg_o   = cfg_q;
  assign start_o = cfg_q[START_BIT];
endmodule

// File: rtl/la_cmd_assembler.sv
module la_cmd_assembler
  import la_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] rx_data_i,
  input  logic              rx_valid_i,
  output logic              cmd_vld_o,
  output cmd_t              cmd_o
);
  asm_state_e        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-1:0] op_q, op_d;
  logic [WORD_W-1:0] arg_q, arg_d;
  logic              vld_q, vld_d;
  cmd_t              out_q, out_d;
  logic              frame_en;

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    op_d     = op_q;
    arg_d    = arg_q;
    vld_d    = 1'b0;
    out_d    = out_q;
    frame_en = rx_valid_i;
    if (rx_valid_i) begin
      case (state_q)
        ASM_IDLE: begin
          if (rx_data_i[BYTE_W-1]) begin
            state_d = ASM_ARGS;
            op_d    = rx_data_i;
            cnt_d   = '0;
            arg_d   = '0;
          end else begin
            vld_d     = 1'b1;
            out_d.op  = rx_data_i;
            out_d.arg = '0;
          end
        end
        ASM_ARGS: begin
          arg_d = {rx_data_i, arg_q[WORD_W-1:BYTE_W]};
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == CNT_W'(ARG_BYTES - 1)) begin
            state_d   = ASM_IDLE;
            vld_d     = 1'b1;
            out_d.op  = op_q;
            out_d.arg = {rx_data_i, arg_q[WORD_W-1:BYTE_W]};
          end
        end
        default: state_d = ASM_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ASM_IDLE;
      cnt_q   <= '0;
      op_q    <= '0;
      arg_q   <= '0;
      out_q   <= '0;
    end else if (frame_en) begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      op_q    <= op_d;
      arg_q   <= arg_d;
      out_q   <= out_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  assign cmd_vld_o = vld_q;
  assign cmd_o     = vld_q ? out_q : '0;
endmodule

// File: rtl/la_cmd_regfile.sv
module la_cmd_regfile
  import la_cmd_pkg::*;
#(
  parameter int unsigned STAGES    = 4,
  parameter int unsigned GROUPS    = 4,
  parameter int unsigned GROUP_LSB = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cmd_vld_i,
  input  cmd_t                     cmd_i,
  output logic [WORD_W*STAGES-1:0] trig_mask_o,
  output logic [WORD_W*STAGES-1:0] trig_value_o,
  output logic [WORD_W*STAGES-1:0] trig_cfg_o,
  output logic [STAGES-1:0]        trig_start_o,
  output logic [DIV_W-1:0]         divider_o,
  output logic [WORD_W-1:0]        read_m1_o,
  output logic [WORD_W-1:0]        delay_m1_o,
  output logic [WORD_W-1:0]        flags_o,
  output logic [GROUPS-1:0]        group_off_o,
  output logic                     reset_pulse_o,
  output logic                     arm_pulse_o
);
  logic wipe, we_div, we_pk, we_flags, we_read, we_delay, we_arm, trig_hit;
  logic [STAGE_W-1:0] stage_idx;
  trig_fld_e          fld;

  logic [DIV_W-1:0]  div_q, div_d;
  logic [WORD_W-1:0] read_q, read_d;
  logic [WORD_W-1:0] delay_q, delay_d;
  logic [WORD_W-1:0] flags_q, flags_d;
  logic              rstp_q, armp_q;
  logic              cfg_en;

  always_comb begin
    wipe      = cmd_vld_i && (cmd_i.op == OP_RESET);
    we_arm    = cmd_vld_i && (cmd_i.op == OP_ARM);
    we_div    = cmd_vld_i && (cmd_i.op == OP_DIV);
    we_pk     = cmd_vld_i && (cmd_i.op == OP_SIZE_PK);
    we_flags  = cmd_vld_i && (cmd_i.op == OP_FLAGS);
    we_read   = cmd_vld_i && (cmd_i.op == OP_READ_CNT);
    we_delay  = cmd_vld_i && (cmd_i.op == OP_DELAY_CNT);
    trig_hit  = cmd_vld_i && (cmd_i.op[7:4] == OP_TRIG_HI);
    stage_idx = cmd_i.op[3:2];
    fld       = trig_fld_e'(cmd_i.op[1:0]);
  end

  always_comb begin
    div_d   = div_q;
    read_d  = read_q;
    delay_d = delay_q;
    flags_d = flags_q;
    cfg_en  = wipe | we_div | we_pk | we_flags | we_read | we_delay;
    if (wipe) begin
      div_d   = '0;
      read_d  = '0;
      delay_d = '0;
      flags_d = '0;
    end else begin
      if (we_div)   div_d   = cmd_i.arg[DIV_W-1:0];
      if (we_flags) flags_d = cmd_i.arg;
      if (we_pk) begin
        read_d  = {{HALF_W{1'b0}}, cmd_i.arg[HALF_W-1:0]};
        delay_d = {{HALF_W{1'b0}}, cmd_i.arg[WORD_W-1:HALF_W]};
      end
      if (we_read)  read_d  = cmd_i.arg;
      if (we_delay) delay_d = cmd_i.arg;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q   <= '0;
      read_q  <= '0;
      delay_q <= '0;
      flags_q <= '0;
    end else if (cfg_en) begin
      div_q   <= div_d;
      read_q  <= read_d;
      delay_q <= delay_d;
      flags_q <= flags_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rstp_q <= 1'b0;
      armp_q <= 1'b0;
    end else begin
      rstp_q <= wipe;
      armp_q <= we_arm;
    end
  end

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [WORD_W-1:0] mask_w, value_w, cfg_w;
    logic              start_w;
    logic              wr_w;
    assign wr_w = trig_hit && (stage_idx == STAGE_W'(s));
    la_trig_stage i_stage (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear_i (wipe),
      .wr_en_i (wr_w),
      .fld_i   (fld),
      .data_i  (cmd_i.arg),
      .mask_o  (mask_w),
      .value_o (value_w),
      .cfg_o   (cfg_w),
      .start_o (start_w)
    );
    assign trig_mask_o[s*WORD_W +: WORD_W]  = mask_w;
    assign trig_value_o[s*WORD_W +: WORD_W] = value_w;
    assign trig_cfg_o[s*WORD_W +: WORD_W]   = cfg_w;
    assign trig_start_o[s]                  = start_w;
  end

  assign divider_o     = div_q;
  assign read_m1_o     = read_q;
  assign delay_m1_o    = delay_q;
  assign flags_o       = flags_q;
  assign group_off_o   = flags_q[GROUP_LSB +: GROUPS];
  assign reset_pulse_o = rstp_q;
  assign arm_pulse_o   = armp_q;
endmodule

// File: rtl/la_cmd_decoder.sv
module la_cmd_decoder
  import la_cmd_pkg::*;
#(
  parameter int unsigned STAGES    = 4,
  parameter int unsigned GROUPS    = 4,
  parameter int unsigned GROUP_LSB = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [7:0]               rx_data_i,
  input  logic                     rx_valid_i,
  output logic                     cmd_strobe_o,
  output logic [7:0]               cmd_opcode_o,
  output logic [31:0]              cmd_arg_o,
  output logic [32*STAGES-1:0]     trig_mask_o,
  output logic [32*STAGES-1:0]     trig_value_o,
  output logic [32*STAGES-1:0]     trig_cfg_o,
  output logic [STAGES-1:0]        trig_start_o,
  output logic [23:0]              divider_o,
  output logic [31:0]              read_m1_o,
  output logic [31:0]              delay_m1_o,
  output logic [31:0]              flags_o,
  output logic [GROUPS-1:0]        group_off_o,
  output logic                     reset_pulse_o,
  output logic                     arm_pulse_o
);
  logic cmd_vld;
  cmd_t cmd;

  la_cmd_assembler i_asm (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_data_i  (rx_data_i),
    .rx_valid_i (rx_valid_i),
    .cmd_vld_o  (cmd_vld),
    .cmd_o      (cmd)
  );

  la_cmd_regfile #(
    .STAGES    (STAGES),
    .GROUPS    (GROUPS),
    .GROUP_LSB (GROUP_LSB)
  ) i_regs (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd_vld_i     (cmd_vld),
    .cmd_i         (cmd),
    .trig_mask_o   (trig_mask_o),
    .trig_value_o  (trig_value_o),
    .trig_cfg_o    (trig_cfg_o),
    .trig_start_o  (trig_start_o),
    .divider_o     (divider_o),
    .read_m1_o     (read_m1_o),
    .delay_m1_o    (delay_m1_o),
    .flags_o       (flags_o),
    .group_off_o   (group_off_o),
    .reset_pulse_o (reset_pulse_o),
    .arm_pulse_o   (arm_pulse_o)
  );

  assign cmd_strobe_o = cmd_vld;
  assign cmd_opcode_o = cmd.op;
  assign cmd_arg_o    = cmd.arg;
endmodule

// File: rtl/la_cmd_decoder_chk.sv
module la_cmd_decoder_chk
  import la_cmd_pkg::*;
#(
  parameter int unsigned STAGES = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [7:0]           rx_data_i,
  input logic                 rx_valid_i,
  input logic                 cmd_strobe_o,
  input logic [7:0]           cmd_opcode_o,
  input logic [31:0]          cmd_arg_o,
  input logic [32*STAGES-1:0] trig_mask_o,
  input logic [23:0]          divider_o,
  input logic [31:0]          read_m1_o,
  input logic [31:0]          delay_m1_o,
  input logic [31:0]          flags_o,
  input logic                 reset_pulse_o,
  input logic                 arm_pulse_o
);
  logic known_long;
  always_comb begin
    known_long = (cmd_opcode_o == OP_DIV) || (cmd_opcode_o == OP_SIZE_PK) ||
                 (cmd_opcode_o == OP_FLAGS) || (cmd_opcode_o == OP_READ_CNT) ||
                 (cmd_opcode_o == OP_DELAY_CNT) ||
                 ((cmd_opcode_o[7:4] == OP_TRIG_HI) && (cmd_opcode_o[1:0] != 2'd3));
  end

  a_r1_long_last_byte: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_strobe_o && cmd_opcode_o[7] |-> $past(rx_valid_i) && ($past(rx_data_i) == cmd_arg_o[31:24]));

  a_r2_short_echo: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_strobe_o && !cmd_opcode_o[7] |-> $past(rx_valid_i) && ($past(rx_data_i) == cmd_opcode_o) && (cmd_arg_o == '0));

  a_r5_divider_load: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_strobe_o && (cmd_opcode_o == OP_DIV) |=> divider_o == $past(cmd_arg_o[23:0]));

  a_r9_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_strobe_o && (cmd_opcode_o == OP_RESET) |=> reset_pulse_o && (flags_o == '0) &&
      (read_m1_o == '0) && (delay_m1_o == '0) && (divider_o == '0) && (trig_mask_o == '0));

  a_r11_arm_source: assert property (@(posedge clk) disable iff (!rst_n)
    arm_pulse_o |-> $past(cmd_strobe_o) && ($past(cmd_opcode_o) == OP_ARM));

  a_r12_unknown_inert: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_strobe_o && cmd_opcode_o[7] && !known_long |=>
      $stable(flags_o) && $stable(divider_o) && $stable(read_m1_o) && $stable(delay_m1_o));
endmodule

bind la_cmd_decoder la_cmd_decoder_chk #(.STAGES(STAGES)) i_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .rx_data_i     (rx_data_i),
  .rx_valid_i    (rx_valid_i),
  .cmd_strobe_o  (cmd_strobe_o),
  .cmd_opcode_o  (cmd_opcode_o),
  .cmd_arg_o     (cmd_arg_o),
  .trig_mask_o   (trig_mask_o),
  .divider_o     (divider_o),
  .read_m1_o     (read_m1_o),
  .delay_m1_o    (delay_m1_o),
  .flags_o       (flags_o),
  .reset_pulse_o (reset_pulse_o),
  .arm_pulse_o   (arm_pulse_o)
);

// File: tb/test_la_cmd_decoder.sv
`timescale 1ns/1ps
module test_la_cmd_decoder;
  localparam int STAGES = 4;

  logic                 clk;
  logic                 rst_n;
  logic [7:0]           rx_data_i;
  logic                 rx_valid_i;
  logic                 cmd_strobe_o;
  logic [7:0]           cmd_opcode_o;
  logic [31:0]          cmd_arg_o;
  logic [32*STAGES-1:0] trig_mask_o, trig_value_o, trig_cfg_o;
  logic [STAGES-1:0]    trig_start_o;
  logic [23:0]          divider_o;
  logic [31:0]          read_m1_o, delay_m1_o, flags_o;
  logic [3:0]           group_off_o;
  logic                 reset_pulse_o, arm_pulse_o;

  int checks = 0;
  int errors = 0;

  la_cmd_decoder #(.STAGES(STAGES)) i_la_cmd_decoder (
    .clk(clk), .rst_n(rst_n), .rx_data_i(rx_data_i), .rx_valid_i(rx_valid_i),
    .cmd_strobe_o(cmd_strobe_o), .cmd_opcode_o(cmd_opcode_o), .cmd_arg_o(cmd_arg_o),
    .trig_mask_o(trig_mask_o), .trig_value_o(trig_value_o), .trig_cfg_o(trig_cfg_o),
    .trig_start_o(trig_start_o), .divider_o(divider_o), .read_m1_o(read_m1_o),
    .delay_m1_o(delay_m1_o), .flags_o(flags_o), .group_off_o(group_off_o),
    .reset_pulse_o(reset_pulse_o), .arm_pulse_o(arm_pulse_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk);
    rx_data_i  = b;
    rx_valid_i = 1'b1;
    @(negedge clk);
    rx_valid_i = 1'b0;
    rx_data_i  = 8'h00;
  endtask

  task automatic send_long(input logic [7:0] op, input logic [31:0] arg);
    send_byte(op);
    for (int i = 0; i < 4; i++) send_byte(arg[i*8 +: 8]);
  endtask

  task automatic t_reset_state;
    chk("R9 reset divider", {8'h0, divider_o}, 32'h0);
    chk("R9 reset flags", flags_o, 32'h0);
    chk("R2 reset strobe", {31'h0, cmd_strobe_o}, 32'h0);
  endtask

  task automatic t_long_framing;
    send_long(8'h80, 32'hAB345678);
    chk("R1 strobe", {31'h0, cmd_strobe_o}, 32'h1);
    chk("R1 opcode", {24'h0, cmd_opcode_o}, 32'h80);
    chk("R1 arg little-endian", cmd_arg_o, 32'hAB345678);
    @(negedge clk);
    chk("R1 strobe one cycle", {31'h0, cmd_strobe_o}, 32'h0);
    chk("R5 divider low 24 bits", {8'h0, divider_o}, 32'h00345678);
  endtask

  task automatic t_short_arm;
    send_byte(8'h01);
    chk("R2 short strobe", {31'h0, cmd_strobe_o}, 32'h1);
    chk("R2 short opcode", {24'h0, cmd_opcode_o}, 32'h01);
    chk("R2 short arg", cmd_arg_o, 32'h0);
    @(negedge clk);
    chk("R11 arm pulse", {31'h0, arm_pulse_o}, 32'h1);
    chk("R11 no reset pulse", {31'h0, reset_pulse_o}, 32'h0);
    @(negedge clk);
    chk("R11 arm pulse ends", {31'h0, arm_pulse_o}, 32'h0);
  endtask

  task automatic t_triggers;
    for (int s = 0; s < STAGES; s++) begin
      send_long(8'hC0 + 8'(4*s), 32'h1111_0000 + 32'(s));
      send_long(8'hC1 + 8'(4*s), 32'h2222_0000 + 32'(s));
      send_long(8'hC2 + 8'(4*s), {(s == 2) ? 8'h08 : 8'h00, 8'(s), 16'h0});
    end
    @(negedge clk);
    for (int s = 0; s < STAGES; s++) begin
      chk("R3 stage mask", trig_mask_o[s*32 +: 32], 32'h1111_0000 + 32'(s));
      chk("R3 stage value", trig_value_o[s*32 +: 32], 32'h2222_0000 + 32'(s));
      chk("R4 stage cfg", trig_cfg_o[s*32 +: 32], {(s == 2) ? 8'h08 : 8'h00, 8'(s), 16'h0});
    end
    chk("R4 start flags", {28'h0, trig_start_o}, 32'h4);
  endtask

  task automatic t_sizes;
    send_long(8'h83, 32'hAABBCCDD);
    send_long(8'h84, 32'h01020304);
    @(negedge clk);
    chk("R7 read count", read_m1_o, 32'hAABBCCDD);
    chk("R7 delay count", delay_m1_o, 32'h01020304);
    send_long(8'h81, 32'h0005_0009);
    @(negedge clk);
    chk("R6 packed read", read_m1_o, 32'h9);
    chk("R6 packed delay", delay_m1_o, 32'h5);
  endtask

  task automatic t_flags;
    send_long(8'h82, 32'h8000_0028);
    @(negedge clk);
    chk("R8 flags", flags_o, 32'h8000_0028);
    chk("R8 group off", {28'h0, group_off_o}, 32'hA);
  endtask

  task automatic t_unknown;
    send_long(8'h9F, 32'hFFFF_FFFF);
    send_long(8'hC3, 32'hDEAD_BEEF);
    send_byte(8'h7E);
    @(negedge clk);
    chk("R12 flags kept", flags_o, 32'h8000_0028);
    chk("R12 divider kept", {8'h0, divider_o}, 32'h00345678);
    chk("R12 read kept", read_m1_o, 32'h9);
    chk("R12 stage0 mask kept", trig_mask_o[31:0], 32'h1111_0000);
    chk("R12 stage0 value kept", trig_value_o[31:0], 32'h2222_0000);
    chk("R12 stage0 cfg kept", trig_cfg_o[31:0], 32'h0);
    send_long(8'h82, 32'h0000_003C);
    @(negedge clk);
    chk("R12 framing intact", flags_o, 32'h3C);
  endtask

  task automatic t_reset_cmd;
    send_byte(8'h00);
    chk("R9 reset strobe", {31'h0, cmd_strobe_o}, 32'h1);
    @(negedge clk);
    chk("R9 reset pulse", {31'h0, reset_pulse_o}, 32'h1);
    chk("R9 flags cleared", flags_o, 32'h0);
    chk("R9 read cleared", read_m1_o, 32'h0);
    chk("R9 delay cleared", delay_m1_o, 32'h0);
    chk("R9 divider cleared", {8'h0, divider_o}, 32'h0);
    chk("R9 masks cleared", trig_mask_o[127:96] | trig_mask_o[31:0], 32'h0);
    chk("R9 start cleared", {28'h0, trig_start_o}, 32'h0);
    @(negedge clk);
    chk("R9 pulse ends", {31'h0, reset_pulse_o}, 32'h0);
  endtask

  task automatic t_resync;
    send_byte(8'h80);
    send_byte(8'h11);
    for (int i = 0; i < 5; i++) send_byte(8'h00);
    @(negedge clk);
    chk("R10 divider cleared by trailing zeros", {8'h0, divider_o}, 32'h0);
    send_long(8'h80, 32'h1234_5678);
    chk("R10 new command framed", cmd_arg_o, 32'h1234_5678);
    @(negedge clk);
    chk("R10 divider after resync", {8'h0, divider_o}, 32'h345678);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n      = 1'b0;
    rx_data_i  = 8'h00;
    rx_valid_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_long_framing();
    t_short_arm();
    t_triggers();
    t_sizes();
    t_flags();
    t_unknown();
    t_reset_cmd();
    t_resync();
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule